// File: doc/BRIEF.md
# Motor Bridge Fault Supervisor

This block watches the protection indications around a single H-bridge motor stage and turns them into control requests and a fault status byte. Four sources arrive as synchronous levels: a sense-resistor current-limit comparator, a per-switch overcurrent comparator, an undervoltage comparator and an overtemperature flag. Each source is filtered by a consecutive-sample timer where needed and is handled by its own rule. A short current-limit event only asks the PWM controller to cut duty, and a long one raises a fault while the bridge keeps running. An overcurrent event shuts the bridge and stays latched until software clears it. Undervoltage and overtemperature shut the bridge only while they are present.

The PWM controller consumes two requests: `duty_reduce` and `bridge_off`. The host sees an active-low fault line and a status byte, and writes through a one-cycle write strobe that targets either the bridge-control register or the status register. Only the clear side effects of those writes are handled here. The direction field of a control write clears the current-limit fault when it selects coast or brake. Bit 7 of a status write clears every latched source.

All timer lengths are parameters counted in system clocks. The defaults correspond to roughly 3 µs, 275 ms and 2 µs at a 10 MHz clock.

Top module: `mdrv_fault_sup`

## Requirements
- R1: After reset, `status` reads 0x00, `fault_n` is 1, and `duty_reduce` and `bridge_off` are 0.
- R2: `duty_reduce` goes high at the clock edge that samples `ilim_cmp` high for the ILIM_DLY-th consecutive time. It goes low at the first edge that samples `ilim_cmp` low. A shorter high run never raises it.
- R3: Status bit 4 (current-limit fault) is set at the edge that samples `ilim_cmp` high for the ILIM_FLT-th consecutive time. It stays set after the comparator drops, and it never raises `bridge_off` on its own.
- R4: Status bit 1 (overcurrent) is set at the edge that samples `ocp_cmp` high for the OCP_DLY-th consecutive time. It then stays set and holds `bridge_off` high until a clear, even after `ocp_cmp` falls.
- R5: Status bit 3 (overtemperature) equals `ot_flag` as sampled at the previous edge, and `bridge_off` is high while it is set.
- R6: Status bit 2 (undervoltage) equals `uv_cmp` as sampled at the previous edge, and `bridge_off` is high while it is set.
- R7: Status bit 0 is the OR of bits 4..1, and `fault_n` is its inverse.
- R8: A write with `wr_sel`=1 and `wr_data[7]`=1 clears bits 4..1 at that edge. A source still present sets its bit again at the next edge. A write with `wr_sel`=1 and `wr_data[7]`=0 changes nothing.
- R9: A write with `wr_sel`=0 whose `wr_data[1:0]` is 00 or 11 clears bit 4 only. The values 01 and 10 clear nothing.
- R10: Status bits 7..5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ilim_cmp | input | 1 | Current-limit comparator, high when the sense voltage exceeds its reference |
| ocp_cmp | input | 1 | Overcurrent comparator, OR of all switch detectors |
| uv_cmp | input | 1 | High while the supply is below the lockout threshold |
| ot_flag | input | 1 | High while the die is too hot |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 1 | Write target: 0 bridge control, 1 status |
| wr_data | input | 8 | Write data |
| status | output | 8 | Fault status byte |
| fault_n | output | 1 | Active-low fault indication |
| duty_reduce | output | 1 | Request to the PWM controller to lower duty |
| bridge_off | output | 1 | Request to the PWM controller to disable all switches |

## Verification
The hardest state to reach from the ports is a current-limit fault that is cleared while the comparator is still high, because it needs a long unbroken comparator run. Once that run is in place, coast or brake control writes and status clear writes must land inside it. A second hard case is an overcurrent clear that lands while the comparator is still asserted, which must relatch on the next edge. The stimulus holds `ilim_cmp` and `ocp_cmp` in long runs that rarely toggle, and it scatters writes with random data through them. Directed sequences then place the clears inside saturated runs. A per-cycle model of run lengths and latched bits checks every output at every cycle.

// File: rtl/mdrv_fault_sup.sv
module mdrv_fault_sup #(
  parameter int unsigned ILIM_DLY = 30,
  parameter int unsigned ILIM_FLT = 2_750_000,
  parameter int unsigned OCP_DLY  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ilim_cmp,
  input  logic       ocp_cmp,
  input  logic       uv_cmp,
  input  logic       ot_flag,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] status,
  output logic       fault_n,
  output logic       duty_reduce,
  output logic       bridge_off
);
  localparam int DW = $clog2(ILIM_DLY + 1);
  localparam int FW = $clog2(ILIM_FLT + 1);
  localparam int OW = $clog2(OCP_DLY + 1);
  localparam logic [DW-1:0] DLY_MAX = DW'(ILIM_DLY);
  localparam logic [FW-1:0] FLT_MAX = FW'(ILIM_FLT);
  localparam logic [OW-1:0] OCP_MAX = OW'(OCP_DLY);

  logic [DW-1:0] dly_cnt;
  logic [FW-1:0] flt_cnt;
  logic [OW-1:0] ocp_cnt;
  logic il_q, oc_q, ot_q, uv_q, any_flt;

  wire flt_hit = ilim_cmp && (flt_cnt >= FLT_MAX - 1'b1);
  wire ocp_hit = ocp_cmp  && (ocp_cnt >= OCP_MAX - 1'b1);
  wire clr_all = wr_en && wr_sel && wr_data[7];
  wire clr_il  = clr_all || (wr_en && !wr_sel && (wr_data[1] == wr_data[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_cnt <= '0;
      flt_cnt <= '0;
      ocp_cnt <= '0;
    end else begin
      if (!ilim_cmp) dly_cnt <= '0;
      else if (dly_cnt != DLY_MAX) dly_cnt <= dly_cnt + 1'b1;
      if (!ilim_cmp) flt_cnt <= '0;
      else if (flt_cnt != FLT_MAX) flt_cnt <= flt_cnt + 1'b1;
      if (!ocp_cmp) ocp_cnt <= '0;
      else if (ocp_cnt != OCP_MAX) ocp_cnt <= ocp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_q <= 1'b0;
      oc_q <= 1'b0;
      ot_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      il_q <= clr_il  ? 1'b0 : (il_q | flt_hit);
      oc_q <= clr_all ? 1'b0 : (oc_q | ocp_hit);
      ot_q <= clr_all ? 1'b0 : ot_flag;
      uv_q <= clr_all ? 1'b0 : uv_cmp;
    end
  end

  assign any_flt     = il_q | oc_q | ot_q | uv_q;
  assign status      = {3'b000, il_q, ot_q, uv_q, oc_q, any_flt};
  assign fault_n     = ~any_flt;
  assign duty_reduce = (dly_cnt == DLY_MAX);
  assign bridge_off  = oc_q | ot_q | uv_q;
endmodule

// File: rtl/mdrv_fault_sup_chk.sv
module mdrv_fault_sup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ilim_cmp,
  input logic       ocp_cmp,
  input logic       uv_cmp,
  input logic       ot_flag,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] status,
  input logic       fault_n,
  input logic       duty_reduce,
  input logic       bridge_off
);
  wire clr_w = wr_en && wr_sel && wr_data[7];

  assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ilim_cmp |=> !duty_reduce);
  assert_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4:1] == 4'b1000) |-> !bridge_off);
  assert_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clr_w) |=> status[1]);
  assert_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> bridge_off);
  assert_hot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_flag && !clr_w) |=> status[3]);
  assert_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_cmp && !clr_w) |=> status[2]);
  assert_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n == !(|status[4:1]));
  assert_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000);
endmodule

bind mdrv_fault_sup mdrv_fault_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ilim_cmp(ilim_cmp), .ocp_cmp(ocp_cmp),
  .uv_cmp(uv_cmp), .ot_flag(ot_flag), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .status(status), .fault_n(fault_n),
  .duty_reduce(duty_reduce), .bridge_off(bridge_off)
);

// File: tb/sim_mdrv_fault_sup.sv
module sim_mdrv_fault_sup;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;
  localparam int FLT = 40;
  localparam int OCP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ilim_cmp = 0, ocp_cmp = 0, uv_cmp = 0, ot_flag = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] status;
  logic fault_n, duty_reduce, bridge_off;

  int checks = 0, fails = 0;
  int il_run = 0, oc_run = 0;
  logic m_il = 0, m_oc = 0, m_ot = 0, m_uv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrv_fault_sup #(.ILIM_DLY(DLY), .ILIM_FLT(FLT), .OCP_DLY(OCP)) u0 (
    .clk(clk), .rst_n(rst_n), .ilim_cmp(ilim_cmp), .ocp_cmp(ocp_cmp),
    .uv_cmp(uv_cmp), .ot_flag(ot_flag), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(status), .fault_n(fault_n),
    .duty_reduce(duty_reduce), .bridge_off(bridge_off));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic any = m_il | m_oc | m_ot | m_uv;
    return {3'b000, m_il, m_ot, m_uv, m_oc, any};
  endfunction

  task automatic compare();
    logic [7:0] e = exp_status();
    chk(duty_reduce == (il_run >= DLY), "R2 duty_reduce", duty_reduce, il_run >= DLY);
    chk(status[4] == e[4], "R3 R9 ilimit bit", status[4], e[4]);
    chk(status[1] == e[1], "R4 ocp bit", status[1], e[1]);
    chk(status[3] == e[3], "R5 ots bit", status[3], e[3]);
    chk(status[2] == e[2], "R6 uvlo bit", status[2], e[2]);
    chk(status[0] == e[0] && fault_n == !e[0], "R7 fault summary", {status[0], fault_n}, {e[0], !e[0]});
    chk(bridge_off == (m_oc | m_ot | m_uv), "R4 R5 R6 bridge_off", bridge_off, m_oc | m_ot | m_uv);
    chk(status[7:5] == 3'b000, "R10 upper bits", status[7:5], 0);
  endtask

  task automatic cyc(input logic il, input logic oc, input logic uv, input logic ot,
                     input logic we, input logic sel, input logic [7:0] d);
    logic clr, cclr;
    @(negedge clk);
    compare();
    ilim_cmp = il; ocp_cmp = oc; uv_cmp = uv; ot_flag = ot;
    wr_en = we; wr_sel = sel; wr_data = d;
    clr  = we && sel && d[7];
    cclr = clr || (we && !sel && (d[1] == d[0]));
    il_run = il ? (il_run < 1000000 ? il_run + 1 : il_run) : 0;
    oc_run = oc ? (oc_run < 1000000 ? oc_run + 1 : oc_run) : 0;
    m_il = cclr ? 1'b0 : (m_il | (il_run >= FLT));
    m_oc = clr  ? 1'b0 : (m_oc | (oc_run >= OCP));
    m_ot = clr  ? 1'b0 : ot;
    m_uv = clr  ? 1'b0 : uv;
  endtask

  task automatic idle(input logic il, input logic oc, input int n);
    for (int i = 0; i < n; i++) cyc(il, oc, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    chk(status == 8'h00, "R1 status after reset", status, 8'h00);
    chk(fault_n && !duty_reduce && !bridge_off, "R1 outputs after reset",
        {fault_n, duty_reduce, bridge_off}, 3'b100);
    rst_n = 1'b1;

    idle(1, 0, DLY - 1); idle(0, 0, 2);
    chk(!duty_reduce, "R2 short run ignored", duty_reduce, 0);
    idle(1, 0, DLY); idle(1, 0, 1);
    chk(duty_reduce, "R2 full run reduces duty", duty_reduce, 1);

    idle(1, 0, FLT);
    chk(status[4] && !bridge_off, "R3 ilimit set, bridge running", {status[4], bridge_off}, 2'b10);
    cyc(1, 0, 0, 0, 1, 0, 8'hC1);
    cyc(1, 0, 0, 0, 0, 0, 8'h00);
    chk(status[4], "R9 control 01 keeps ilimit", status[4], 1);
    cyc(1, 0, 0, 0, 1, 0, 8'h00);
    cyc(1, 0, 0, 0, 0, 0, 8'h00);
    chk(!status[4], "R9 control 00 clears ilimit", status[4], 0);
    cyc(0, 0, 0, 0, 0, 0, 8'h00);
    chk(status[4], "R8 present condition sets again", status[4], 1);
    cyc(0, 0, 0, 0, 1, 0, 8'h03);
    cyc(0, 0, 0, 0, 0, 0, 8'h00);
    chk(status == 8'h00, "R9 control 11 clears ilimit", status, 8'h00);

    idle(0, 1, OCP); idle(0, 0, 1);
    chk(status[1] && bridge_off && !fault_n, "R4 ocp latched", {status[1], bridge_off, fault_n}, 3'b110);
    idle(0, 0, 5);
    cyc(0, 0, 0, 0, 1, 0, 8'h00);
    cyc(0, 0, 0, 0, 1, 1, 8'h7F);
    cyc(0, 0, 0, 0, 0, 0, 8'h00);
    chk(status == 8'h03, "R8 R9 writes without clear keep ocp", status, 8'h03);
    cyc(0, 0, 0, 0, 1, 1, 8'h80);
    cyc(0, 0, 0, 0, 0, 0, 8'h00);
    chk(status == 8'h00 && !bridge_off, "R8 clear releases ocp", status, 8'h00);

    cyc(0, 0, 1, 1, 0, 0, 8'h00);
    cyc(0, 0, 1, 1, 0, 0, 8'h00);
    chk(status == 8'h0D && bridge_off, "R5 R6 ots and uvlo set", status, 8'h0D);
    cyc(0, 0, 0, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 0, 8'h00);
    chk(status == 8'h00 && !bridge_off, "R5 R6 auto recovery", status, 8'h00);

    for (int i = 0; i < 6000; i++) begin
      logic il = ilim_cmp, oc = ocp_cmp, uv = uv_cmp, ot = ot_flag;
      logic we;
      if ($urandom_range(0, 59) == 0) il = !il;
      if ($urandom_range(0, 19) == 0) oc = !oc;
      if ($urandom_range(0, 39) == 0) uv = !uv;
      if ($urandom_range(0, 39) == 0) ot = !ot;
      we = ($urandom_range(0, 14) == 0);
      cyc(il, oc, uv, ot, we, 1'($urandom_range(0, 1)), 8'($urandom));
    end
    idle(0, 0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule